// File: doc/BRIEF.md
# Host Flash Erase Sequencer

This block is the host side of a whole-chip erase for a byte-wide parallel flash. A one-cycle start pulse makes it switch on the high programming voltage and wait a programmable number of cycles for that supply to settle. It then writes the erase command byte 30h twice over the flash bus. Each write uses a shaped write strobe with parameterised setup, low and hold phases.

The block then polls the device by reading address 0 until bit 7 of the returned byte is 1, which marks the end of the erase. A programmable cycle budget bounds this polling. Once polling ends, the block reads every address in ascending order and checks that each byte is FFh. It stops at the first byte that differs. At the end of the sequence it removes the programming voltage, pulses done, and holds the outcome until the next start: pass, timeout, or the failing address.

Top module: `flash_erase_seq`

## Requirements
- R1: While reset is held and right after it, the programming-voltage enable, busy and done are 0, and both the write strobe and the output enable (both active low) are 1.
- R2: A start pulse while idle raises the programming-voltage enable and busy. No write strobe goes low until more than `ramp_cycles_i` cycles after the start pulse was sampled, and the write strobe is never low while the enable is 0.
- R3: Each sequence makes exactly two bus writes, both of data 30h at address 0, before any bus read.
- R4: During a write, address and data are driven unchanged from the falling edge of the write strobe through its rising edge. The write strobe and output enable are never low in the same cycle.
- R5: After the second command write, the block keeps reading address 0 until a returned byte has bit 7 set to 1.
- R6: The poll timer is loaded with `poll_limit_i` when polling begins. If a poll read returns bit 7 = 0 after that timer has run out, the sequence ends with timeout_o = 1 and pass_o = 0, and no verify read is made. A limit of 0 times out on the first busy poll read.
- R7: After a poll read returns bit 7 = 1, the block reads addresses 0 to 2^ADDR_W-1 in ascending order, one read each. If every byte is FFh, the sequence ends with pass_o = 1.
- R8: The first verify read that is not FFh ends the sequence with pass_o = 0, timeout_o = 0 and fail_addr_o set to that address. No further read is made. This includes the first and the last address.
- R9: done_o is high for exactly one cycle at the end of every sequence. In that cycle the programming-voltage enable and busy are already 0, whatever the outcome.
- R10: A start pulse while busy is ignored. The running sequence continues with no further command writes and with one done pulse.
- R11: pass_o, timeout_o and fail_addr_o stay constant while idle, and a new start clears pass_o and timeout_o in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a chip erase |
| ramp_cycles_i | input | CNT_W | Supply settle wait in cycles, sampled at start |
| poll_limit_i | input | CNT_W | Poll budget in cycles, sampled when polling begins |
| vpp_en_o | output | 1 | Programming-voltage enable |
| fl_addr_o | output | ADDR_W | Flash address |
| fl_dq_o | output | 8 | Data driven to the flash |
| fl_dq_oe_o | output | 1 | High while the host drives the data bus |
| fl_dq_i | input | 8 | Data returned by the flash |
| fl_we_n_o | output | 1 | Write strobe, active low |
| fl_oe_n_o | output | 1 | Output enable, active low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| pass_o | output | 1 | Last sequence erased and verified |
| timeout_o | output | 1 | Last sequence ran out of poll budget |
| fail_addr_o | output | ADDR_W | First address that did not read FFh |

## Verification
The outcomes that are hardest to reach from the ports depend on the flash, not the host. These are a poll budget that runs out, a non-FFh byte at the first or the last address, and a restart pulse while a sequence is running. The bench uses a behavioural flash that starts erasing only after two 30h strobes with the supply enabled. Its erase duration is set per case, and it can leave one chosen byte at FEh after the erase. FEh keeps bit 7 set, so a bad byte at address 0 passes polling and fails in verify. A long erase together with a short or zero budget forces the timeout.

// File: rtl/fes_pkg.sv
// Shared encodings for the flash erase sequencer.
// Assumes: byte-wide flash, erase command byte is repeated twice.
package fes_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_RAMP,
        SEQ_CMD1,
        SEQ_CMD2,
        SEQ_POLL,
        SEQ_VERIFY
    } seq_state_t;

    typedef enum logic [2:0] {
        BUS_IDLE,
        BUS_WSETUP,
        BUS_WLOW,
        BUS_WHOLD,
        BUS_READ
    } bus_state_t;

    localparam logic [7:0] ERASE_CMD   = 8'h30;
    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/fes_cycle_timer.sv
// Down-counting cycle timer.
// Does: loads a count, decrements once per cycle, flags when it reaches zero.
// Assumes: load has priority over counting; a zero load reads expired at once.
module fes_cycle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] value_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] count_q;

    // Load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_i) begin
            count_q <= value_i;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign expired_o = (count_q == '0);

endmodule

// File: rtl/fes_bus_engine.sv
// Flash bus cycle engine.
// Does: runs one write or one read cycle per request. A write drives address
//   and data for a setup phase, holds the strobe low, then keeps both for a
//   hold phase. A read holds output enable low and samples data at the end.
// Assumes: requests arrive only while idle; every phase length is at least 1.
module fes_bus_engine
    import fes_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int T_SETUP = 2,
    parameter int T_PULSE = 3,
    parameter int T_HOLD  = 2,
    parameter int T_READ  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_wr_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [7:0]        req_wdata_i,
    output logic              ack_o,
    output logic [7:0]        rdata_o,
    output logic [ADDR_W-1:0] fl_addr_o,
    output logic [7:0]        fl_dq_o,
    output logic              fl_dq_oe_o,
    input  logic [7:0]        fl_dq_i,
    output logic              fl_we_n_o,
    output logic              fl_oe_n_o
);

    localparam int MAX_WA = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
    localparam int MAX_WB = (T_HOLD > T_READ) ? T_HOLD : T_READ;
    localparam int MAX_PH = (MAX_WA > MAX_WB) ? MAX_WA : MAX_WB;
    localparam int PH_W   = $clog2(MAX_PH + 1);

    bus_state_t        state_q;
    logic [PH_W-1:0]   ph_cnt_q;
    logic [PH_W-1:0]   ph_last;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        wdata_q;
    logic [7:0]        rdata_q;
    logic              ack_q;

    // Last count value of the current phase.
    always_comb begin
        case (state_q)
            BUS_WSETUP: ph_last = PH_W'(T_SETUP - 1);
            BUS_WLOW:   ph_last = PH_W'(T_PULSE - 1);
            BUS_WHOLD:  ph_last = PH_W'(T_HOLD - 1);
            BUS_READ:   ph_last = PH_W'(T_READ - 1);
            default:    ph_last = '0;
        endcase
    end

    // Phase sequencing, request capture and read-data sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= BUS_IDLE;
            ph_cnt_q <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            ack_q    <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            if (state_q == BUS_IDLE) begin
                ph_cnt_q <= '0;
                if (req_i) begin
                    addr_q  <= req_addr_i;
                    wdata_q <= req_wdata_i;
                    state_q <= req_wr_i ? BUS_WSETUP : BUS_READ;
                end
            end else if (ph_cnt_q != ph_last) begin
                ph_cnt_q <= ph_cnt_q + 1'b1;
            end else begin
                ph_cnt_q <= '0;
                case (state_q)
                    BUS_WSETUP: state_q <= BUS_WLOW;
                    BUS_WLOW:   state_q <= BUS_WHOLD;
                    BUS_WHOLD: begin
                        state_q <= BUS_IDLE;
                        ack_q   <= 1'b1;
                    end
                    BUS_READ: begin
                        state_q <= BUS_IDLE;
                        rdata_q <= fl_dq_i;
                        ack_q   <= 1'b1;
                    end
                    default: state_q <= BUS_IDLE;
                endcase
            end
        end
    end

    assign ack_o      = ack_q;
    assign rdata_o    = rdata_q;
    assign fl_addr_o  = addr_q;
    assign fl_dq_o    = wdata_q;
    assign fl_dq_oe_o = (state_q == BUS_WSETUP) || (state_q == BUS_WLOW) ||
                        (state_q == BUS_WHOLD);
    assign fl_we_n_o  = (state_q != BUS_WLOW);
    assign fl_oe_n_o  = (state_q != BUS_READ);

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n_o && !fl_oe_n_o));

    // R4
    wr_hold_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n_o) |-> (fl_dq_oe_o && $stable(fl_dq_o) && $stable(fl_addr_o)));

endmodule

// File: rtl/fes_seq_ctrl.sv
// Erase sequence controller.
// Does: supply enable and ramp wait, two command writes, bit-7 polling with a
//   cycle budget, full-array FFh readback, then result reporting.
// Assumes: one bus request is outstanding at most; the bus engine acks each.
module fes_seq_ctrl
    import fes_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  ramp_cycles_i,
    input  logic [CNT_W-1:0]  poll_limit_i,
    output logic              tmr_load_o,
    output logic [CNT_W-1:0]  tmr_value_o,
    input  logic              tmr_expired_i,
    output logic              bus_req_o,
    output logic              bus_wr_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [7:0]        bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic [7:0]        bus_rdata_i,
    output logic              vpp_en_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              timeout_o,
    output logic [ADDR_W-1:0] fail_addr_o
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    seq_state_t        state_q;
    logic              wait_ack_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic              vpp_q;
    logic              done_q;
    logic              pass_q;
    logic              tmo_q;
    logic [ADDR_W-1:0] fail_addr_q;
    logic              bus_phase;

    assign bus_phase = (state_q == SEQ_CMD1) || (state_q == SEQ_CMD2) ||
                       (state_q == SEQ_POLL) || (state_q == SEQ_VERIFY);

    // Timer load: ramp count at start, poll budget once commands are sent.
    always_comb begin
        tmr_load_o  = 1'b0;
        tmr_value_o = ramp_cycles_i;
        if (state_q == SEQ_IDLE && start_i) begin
            tmr_load_o = 1'b1;
        end else if (state_q == SEQ_CMD2 && wait_ack_q && bus_ack_i) begin
            tmr_load_o  = 1'b1;
            tmr_value_o = poll_limit_i;
        end
    end

    // Bus request decode: one request per bus state visit.
    always_comb begin
        bus_req_o   = bus_phase && !wait_ack_q;
        bus_wr_o    = (state_q == SEQ_CMD1) || (state_q == SEQ_CMD2);
        bus_addr_o  = (state_q == SEQ_VERIFY) ? cur_addr_q : '0;
        bus_wdata_o = ERASE_CMD;
    end

    // Sequence state machine and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SEQ_IDLE;
            wait_ack_q  <= 1'b0;
            cur_addr_q  <= '0;
            vpp_q       <= 1'b0;
            done_q      <= 1'b0;
            pass_q      <= 1'b0;
            tmo_q       <= 1'b0;
            fail_addr_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (start_i) begin
                        state_q     <= SEQ_RAMP;
                        vpp_q       <= 1'b1;
                        pass_q      <= 1'b0;
                        tmo_q       <= 1'b0;
                        fail_addr_q <= '0;
                        wait_ack_q  <= 1'b0;
                        cur_addr_q  <= '0;
                    end
                end
                SEQ_RAMP: begin
                    if (tmr_expired_i) state_q <= SEQ_CMD1;
                end
                default: begin
                    if (!wait_ack_q) begin
                        wait_ack_q <= 1'b1;
                    end else if (bus_ack_i) begin
                        wait_ack_q <= 1'b0;
                        case (state_q)
                            SEQ_CMD1: state_q <= SEQ_CMD2;
                            SEQ_CMD2: state_q <= SEQ_POLL;
                            SEQ_POLL: begin
                                if (bus_rdata_i[7]) begin
                                    state_q    <= SEQ_VERIFY;
                                    cur_addr_q <= '0;
                                end else if (tmr_expired_i) begin
                                    state_q <= SEQ_IDLE;
                                    vpp_q   <= 1'b0;
                                    done_q  <= 1'b1;
                                    tmo_q   <= 1'b1;
                                end
                            end
                            SEQ_VERIFY: begin
                                if (bus_rdata_i != ERASED_BYTE) begin
                                    state_q     <= SEQ_IDLE;
                                    vpp_q       <= 1'b0;
                                    done_q      <= 1'b1;
                                    fail_addr_q <= cur_addr_q;
                                end else if (cur_addr_q == LAST_ADDR) begin
                                    state_q <= SEQ_IDLE;
                                    vpp_q   <= 1'b0;
                                    done_q  <= 1'b1;
                                    pass_q  <= 1'b1;
                                end else begin
                                    cur_addr_q <= cur_addr_q + 1'b1;
                                end
                            end
                            default: state_q <= SEQ_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end

    assign vpp_en_o    = vpp_q;
    assign busy_o      = (state_q != SEQ_IDLE);
    assign done_o      = done_q;
    assign pass_o      = pass_q;
    assign timeout_o   = tmo_q;
    assign fail_addr_o = fail_addr_q;

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!vpp_en_o && !busy_o));

    // R6
    tmo_not_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !pass_o);

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(pass_o) && $stable(timeout_o) && $stable(fail_addr_o)));

endmodule

// File: rtl/flash_erase_seq.sv
// Host flash erase sequencer top.
// Does: ties the sequence controller, its cycle timer and the bus engine.
// Assumes: the programming supply is controlled only through vpp_en_o.
module flash_erase_seq #(
    parameter int ADDR_W  = 6,
    parameter int CNT_W   = 16,
    parameter int T_SETUP = 2,
    parameter int T_PULSE = 3,
    parameter int T_HOLD  = 2,
    parameter int T_READ  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  ramp_cycles_i,
    input  logic [CNT_W-1:0]  poll_limit_i,
    output logic              vpp_en_o,
    output logic [ADDR_W-1:0] fl_addr_o,
    output logic [7:0]        fl_dq_o,
    output logic              fl_dq_oe_o,
    input  logic [7:0]        fl_dq_i,
    output logic              fl_we_n_o,
    output logic              fl_oe_n_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              timeout_o,
    output logic [ADDR_W-1:0] fail_addr_o
);

    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_value;
    logic              tmr_expired;
    logic              bus_req;
    logic              bus_wr;
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0]        bus_wdata;
    logic              bus_ack;
    logic [7:0]        bus_rdata;

    fes_cycle_timer #(.CNT_W(CNT_W)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .value_i   (tmr_value),
        .expired_o (tmr_expired)
    );

    fes_seq_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .ramp_cycles_i (ramp_cycles_i),
        .poll_limit_i  (poll_limit_i),
        .tmr_load_o    (tmr_load),
        .tmr_value_o   (tmr_value),
        .tmr_expired_i (tmr_expired),
        .bus_req_o     (bus_req),
        .bus_wr_o      (bus_wr),
        .bus_addr_o    (bus_addr),
        .bus_wdata_o   (bus_wdata),
        .bus_ack_i     (bus_ack),
        .bus_rdata_i   (bus_rdata),
        .vpp_en_o      (vpp_en_o),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .pass_o        (pass_o),
        .timeout_o     (timeout_o),
        .fail_addr_o   (fail_addr_o)
    );

    fes_bus_engine #(
        .ADDR_W (ADDR_W),
        .T_SETUP(T_SETUP),
        .T_PULSE(T_PULSE),
        .T_HOLD (T_HOLD),
        .T_READ (T_READ)
    ) bus_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (bus_req),
        .req_wr_i    (bus_wr),
        .req_addr_i  (bus_addr),
        .req_wdata_i (bus_wdata),
        .ack_o       (bus_ack),
        .rdata_o     (bus_rdata),
        .fl_addr_o   (fl_addr_o),
        .fl_dq_o     (fl_dq_o),
        .fl_dq_oe_o  (fl_dq_oe_o),
        .fl_dq_i     (fl_dq_i),
        .fl_we_n_o   (fl_we_n_o),
        .fl_oe_n_o   (fl_oe_n_o)
    );

    // R2
    wr_supply_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n_o |-> vpp_en_o);

endmodule

// File: tb/flash_erase_seq_tb_top.sv
// Scoreboard bench: run_case pushes the expected outcome, the monitor pops it
// on done_o and compares it with the ports and with the bus activity seen.
module flash_erase_seq_tb_top;

    localparam int ADDR_W = 6;
    localparam int CNT_W  = 16;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef struct {
        bit exp_pass;
        bit exp_tmo;
        int exp_fa;
        int exp_nv;
        int min_poll;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [CNT_W-1:0]  ramp_cycles_i = '0;
    logic [CNT_W-1:0]  poll_limit_i = '0;
    logic              vpp_en_o;
    logic [ADDR_W-1:0] fl_addr_o;
    logic [7:0]        fl_dq_o;
    logic              fl_dq_oe_o;
    logic [7:0]        fl_dq_i;
    logic              fl_we_n_o;
    logic              fl_oe_n_o;
    logic              busy_o;
    logic              done_o;
    logic              pass_o;
    logic              timeout_o;
    logic [ADDR_W-1:0] fail_addr_o;

    always #10 clk = ~clk;

    flash_erase_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .ramp_cycles_i(ramp_cycles_i), .poll_limit_i(poll_limit_i),
        .vpp_en_o(vpp_en_o), .fl_addr_o(fl_addr_o), .fl_dq_o(fl_dq_o),
        .fl_dq_oe_o(fl_dq_oe_o), .fl_dq_i(fl_dq_i), .fl_we_n_o(fl_we_n_o),
        .fl_oe_n_o(fl_oe_n_o), .busy_o(busy_o), .done_o(done_o),
        .pass_o(pass_o), .timeout_o(timeout_o), .fail_addr_o(fail_addr_o)
    );

    int checks = 0;
    int errors = 0;
    exp_t exp_q[$];

    // Behavioural flash and bus observation state
    logic [7:0] mem [DEPTH];
    logic [7:0] rd_latch = 8'h00;
    bit   case_active = 0;
    bit   case_done = 0;
    bit   erasing = 0;
    bit   stage1 = 0;
    bit   bad_en = 0;
    int   bad_idx = 0;
    int   erase_time = 0;
    int   erase_left = 0;
    int   cyc = 0;
    int   start_cyc = 0;
    int   first_we_cyc = -1;
    int   n_writes = 0;
    int   n_poll = 0;
    int   n_verify = 0;
    int   exp_vaddr = 0;
    bit   in_verify = 0;
    bit   wr_bad = 0;
    bit   wr_unstable = 0;
    bit   poll_bad = 0;
    bit   order_bad = 0;
    bit   rd_early = 0;
    logic [7:0]        fall_data;
    logic [ADDR_W-1:0] fall_addr;

    assign fl_dq_i = fl_oe_n_o ? 8'h00 : rd_latch;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Erase timing of the model
    always @(posedge clk) begin
        if (erasing) begin
            if (erase_left <= 1) begin
                erasing = 0;
                for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
                if (bad_en) mem[bad_idx] = 8'hFE;
            end else begin
                erase_left = erase_left - 1;
            end
        end
    end

    // First strobe cycle, measured away from the edge
    always @(negedge clk) begin
        if (case_active && rst_n && fl_we_n_o === 1'b0 && first_we_cyc < 0)
            first_we_cyc = cyc;
    end

    always @(negedge fl_we_n_o) begin
        if (case_active) begin
            fall_data = fl_dq_o;
            fall_addr = fl_addr_o;
            if (!fl_dq_oe_o || !vpp_en_o) wr_bad = 1;
        end
    end

    always @(posedge fl_we_n_o) begin
        if (case_active && rst_n) begin
            n_writes++;
            if (fl_dq_o !== fall_data || fl_addr_o !== fall_addr || !fl_dq_oe_o)
                wr_unstable = 1;
            if (fl_dq_o !== 8'h30 || fl_addr_o !== '0) wr_bad = 1;
            if (fl_dq_o === 8'h30 && vpp_en_o) begin
                if (stage1) begin
                    stage1 = 0;
                    erasing = 1;
                    erase_left = erase_time;
                end else begin
                    stage1 = 1;
                end
            end
        end
    end

    always @(negedge fl_oe_n_o) begin
        if (case_active && rst_n) begin
            rd_latch = erasing ? 8'h00 : mem[fl_addr_o];
            if (n_writes < 2) rd_early = 1;
            if (!in_verify) begin
                n_poll++;
                if (fl_addr_o !== '0) poll_bad = 1;
                if (rd_latch[7]) in_verify = 1;
            end else begin
                n_verify++;
                if (int'(fl_addr_o) != exp_vaddr) order_bad = 1;
                exp_vaddr++;
            end
        end
    end

    // Monitor: pop the expected outcome on each done pulse and compare
    always @(negedge clk) begin
        if (rst_n && done_o === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk(0, "R10", "unexpected done pulse", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(pass_o == e.exp_pass, "R7", "pass_o", int'(pass_o), int'(e.exp_pass));
                chk(timeout_o == e.exp_tmo, "R6", "timeout_o", int'(timeout_o), int'(e.exp_tmo));
                if (!e.exp_pass && !e.exp_tmo)
                    chk(int'(fail_addr_o) == e.exp_fa, "R8", "fail_addr_o", int'(fail_addr_o), e.exp_fa);
                chk(n_verify == e.exp_nv, "R8", "verify read count", n_verify, e.exp_nv);
                chk(!order_bad, "R7", "verify address order", int'(order_bad), 0);
                chk(n_writes == 2, "R3", "command write count", n_writes, 2);
                chk(!wr_bad && !rd_early, "R3", "command data/address/order", int'(wr_bad), 0);
                chk(!wr_unstable, "R4", "write data held across strobe", int'(wr_unstable), 0);
                chk(!poll_bad && n_poll >= e.min_poll, "R5", "poll reads", n_poll, e.min_poll);
                chk(!vpp_en_o && !busy_o, "R9", "supply off at done", int'(vpp_en_o), 0);
                chk(first_we_cyc - start_cyc > int'(ramp_cycles_i), "R2", "ramp wait cycles",
                    first_we_cyc - start_cyc, int'(ramp_cycles_i) + 1);
            end
            case_done = 1;
        end
    end

    task automatic run_case(input int ramp, input int plimit, input int etime,
                            input bit bad, input int badi, input bit ep,
                            input bit et, input int efa, input int env,
                            input int minp, input bit restart);
        exp_t e;
        bit   ok_seen;
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'(i * 7 + 1) & 8'h7F;
        erasing = 0; stage1 = 0; bad_en = bad; bad_idx = badi; erase_time = etime;
        first_we_cyc = -1; n_writes = 0; n_poll = 0; n_verify = 0; exp_vaddr = 0;
        in_verify = 0; wr_bad = 0; wr_unstable = 0; poll_bad = 0; order_bad = 0;
        rd_early = 0; case_done = 0;
        e.exp_pass = ep; e.exp_tmo = et; e.exp_fa = efa; e.exp_nv = env; e.min_poll = minp;
        exp_q.push_back(e);
        @(negedge clk);
        ramp_cycles_i = CNT_W'(ramp);
        poll_limit_i  = CNT_W'(plimit);
        case_active   = 1;
        start_cyc     = cyc;
        start_i       = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R11: results cleared by start; R2: supply enabled and busy
        chk(!pass_o && !timeout_o, "R11", "results cleared by start", int'(pass_o), 0);
        chk(vpp_en_o && busy_o, "R2", "supply and busy after start", int'(vpp_en_o), 1);
        if (restart) begin
            repeat (40) @(negedge clk);
            // R10: start while busy must be ignored
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        ok_seen = 0;
        for (int w = 0; w < 20000; w++) begin
            @(negedge clk);
            if (case_done) begin
                ok_seen = 1;
                break;
            end
        end
        if (!ok_seen) begin
            chk(0, "R9", "watchdog: no done pulse", 0, 1);
            void'(exp_q.pop_front());
        end else begin
            chk(done_o == 1'b0, "R9", "done one cycle wide", int'(done_o), 0);
            repeat (5) @(negedge clk);
            chk(pass_o == ep && timeout_o == et, "R11", "results held while idle",
                int'(pass_o), int'(ep));
            chk(n_writes == 2 && !busy_o, "R10", "no restart after done", n_writes, 2);
        end
        case_active = 0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(vpp_en_o == 0 && busy_o == 0 && done_o == 0, "R1", "reset outputs low",
            int'(vpp_en_o), 0);
        chk(fl_we_n_o == 1 && fl_oe_n_o == 1, "R1", "strobes idle in reset",
            int'(fl_we_n_o), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(vpp_en_o == 0 && busy_o == 0 && fl_we_n_o == 1 && fl_oe_n_o == 1, "R1",
            "idle after reset", int'(busy_o), 0);

        // R7: full pass
        run_case(20, 1000, 60, 0, 0, 1, 0, 0, DEPTH, 2, 0);
        // R8: failure in the middle
        run_case(5, 1000, 60, 1, 37, 0, 0, 37, 38, 2, 0);
        // R8: failure at the first address
        run_case(3, 1000, 30, 1, 0, 0, 0, 0, 1, 1, 0);
        // R8: failure at the last address
        run_case(8, 1000, 45, 1, DEPTH - 1, 0, 0, DEPTH - 1, DEPTH, 2, 0);
        // R6: budget runs out during a long erase
        run_case(4, 100, 5000, 0, 0, 0, 1, 0, 0, 2, 0);
        // R6: zero budget times out on the first busy poll
        run_case(2, 0, 50, 0, 0, 0, 1, 0, 0, 1, 0);
        // R10: start pulse while busy, zero ramp
        run_case(0, 1000, 80, 0, 0, 1, 0, 0, DEPTH, 2, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule